// File: doc/BRIEF.md
# Memory BIST column-failure recorder

This block sits beside the self-test engine of a banked cache data array that is split into quadrants. While a test session runs, the engine sends one report per detected failure: the quadrant, the bank, the failing column number, and whether that column belongs to the high or the low half of the bank. For each quadrant the recorder keeps a two-slot log of failures. Each slot holds a bank number, a bad high column and a bad low column. The result is a 34-bit status word per quadrant that repair logic or a debug reader can use.

A slot that has never been used reads as all ones: bank 0x7, and 0x7F in both column fields. The column code 0x7E marks a position where two or more bad columns were seen. Once that happens the quadrant can no longer be repaired from that log entry. A single fatal flag goes high as soon as any quadrant records such a fatal marker.

A clear pulse empties every log and opens a session. A done strobe closes the session and freezes all results until the next clear.

Top module: `bist_col_fail_rec`

## Requirements
- R1: After reset every status word reads all ones and the fatal flag is 0. Within a 34-bit word, slot 1 occupies bits 16:0 and slot 2 occupies bits 33:17. Each 17-bit slot is laid out as {bank[2:0], high column[6:0], low column[6:0]}, with the low column in the lowest bits. A slot that holds no failure has bank 0x7 and both column fields at 0x7F.
- R2: A clear pulse (`clr`) restores every slot to the empty value, clears the fatal flag and starts a session. Its effect is visible in the cycle after it is sampled.
- R3: Within a quadrant, a report for a bank that is not yet logged goes to slot 1 if slot 1 is empty, and to slot 2 otherwise. The slot takes the bank number, and the reported column is written into the field selected by `fail_hi` (1 = high, 0 = low).
- R4: A report whose bank, half and column are already logged changes nothing and does not take a slot.
- R5: A report for a bank that is already logged, whose selected half field is still 0x7F, fills that field in the same slot.
- R6: A report for a logged bank whose selected half field already holds a different column writes 0x7E into that field and sets the fatal flag.
- R7: A report for a third distinct bank in a quadrant, when both slots are taken, writes 0x7E into the selected half field of slot 2 and sets the fatal flag.
- R8: The fatal flag is 1 exactly when some column field of some quadrant reads 0x7E. It stays set until the next clear.
- R9: Reports are ignored before the first clear and after a done strobe (`done`), until the next clear. Status and fatal hold their values meanwhile. A report sampled in the same cycle as done is still taken.
- R10: Reports that carry the reserved column codes 0x7E or 0x7F are ignored.
- R11: When a clear and a report are sampled in the same cycle, the clear wins and the report is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr | input | 1 | Clear logs and start a session |
| done | input | 1 | End the session and freeze the results |
| fail_vld | input | 1 | Failure report strobe |
| fail_quad | input | 2 | Quadrant of the report |
| fail_bank | input | 3 | Bank of the report |
| fail_col | input | 7 | Failing column number |
| fail_hi | input | 1 | 1 = high-half column, 0 = low-half column |
| q_stat | output | 4x34 | Per-quadrant status words, quadrant 0 in the lowest 34 bits |
| fatal | output | 1 | Set when any column field holds the fatal marker |

## Verification
Some properties are checked by assertions on every cycle:
- the fatal flag agrees with the presence of a 0x7E field;
- an empty slot always carries bank 0x7;
- slot 2 is never filled while slot 1 is empty;
- a clear leaves every word empty;
- the fatal flag never rises without a report;
- reserved column codes and out-of-session reports leave the status untouched.

Other behaviour can only be shown by the bench scenarios: that the right slot and half field take the right column, that duplicates are dropped, and that a conflicting column or a third bank produces the marker in the correct place. The bench drives directed cases and a seeded random report stream and compares the status against its own model.

// File: rtl/bist_rec_pkg.sv
package bist_rec_pkg;
   // What a single report does to the slot it selects
   typedef enum logic [1:0] {
      ACT_NONE = 2'd0,
      ACT_FILL = 2'd1,
      ACT_MARK = 2'd2
   } rec_act_e;
endpackage

// File: rtl/bist_quad_log.sv
module bist_quad_log
   import bist_rec_pkg::*;
#(
   parameter int BANK_W = 3,
   parameter int COL_W  = 7,
   parameter int REC_W  = 2 * COL_W + BANK_W,
   parameter int STAT_W = 2 * REC_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_i,
   input  logic              acc_i,
   input  logic [BANK_W-1:0] bank_i,
   input  logic [COL_W-1:0]  col_i,
   input  logic              hi_i,
   output logic [STAT_W-1:0] stat_o,
   output logic              fat_evt_o
);
   localparam logic [COL_W-1:0] EMPTY_C = '1;
   localparam logic [COL_W-1:0] FATAL_C = {{(COL_W-1){1'b1}}, 1'b0};

   logic [1:0]                       used_q;
   logic [1:0][BANK_W-1:0]           bank_q;
   logic [1:0][1:0][COL_W-1:0]       col_q;   // [slot][half]

   logic [1:0]       hit;
   logic             slot;
   logic             alloc;
   logic             ovf;
   logic [COL_W-1:0] cur;
   rec_act_e         act;

   always_comb begin
      for (int k = 0; k < 2; k++) begin
         hit[k] = used_q[k] && (bank_q[k] == bank_i);
      end
      alloc = 1'b0;
      ovf   = 1'b0;
      if (hit[0]) begin
         slot = 1'b0;
      end else if (hit[1]) begin
         slot = 1'b1;
      end else if (!used_q[0]) begin
         slot  = 1'b0;
         alloc = 1'b1;
      end else if (!used_q[1]) begin
         slot  = 1'b1;
         alloc = 1'b1;
      end else begin
         slot = 1'b1;
         ovf  = 1'b1;
      end
      cur = col_q[slot][hi_i];
      if (alloc) begin
         act = ACT_FILL;
      end else if (ovf) begin
         act = (cur == FATAL_C) ? ACT_NONE : ACT_MARK;
      end else if (cur == EMPTY_C) begin
         act = ACT_FILL;
      end else if ((cur == col_i) || (cur == FATAL_C)) begin
         act = ACT_NONE;
      end else begin
         act = ACT_MARK;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clr_i) begin
         used_q <= '0;
         bank_q <= '1;
         col_q  <= '1;
      end else if (acc_i) begin
         case (act)
            ACT_FILL: begin
               used_q[slot]       <= 1'b1;
               bank_q[slot]       <= bank_i;
               col_q[slot][hi_i]  <= col_i;
            end
            ACT_MARK: col_q[slot][hi_i] <= FATAL_C;
            default: ;
         endcase
      end
   end

   assign fat_evt_o = acc_i && (act == ACT_MARK);

   for (genvar k = 0; k < 2; k++) begin : g_pack
      assign stat_o[k*REC_W +: REC_W] = {bank_q[k], col_q[k][1], col_q[k][0]};
   end
endmodule

// File: rtl/bist_rec_seq.sv
module bist_rec_seq #(
   parameter int COL_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             done_i,
   input  logic             vld_i,
   input  logic [COL_W-1:0] col_i,
   input  logic             fat_evt_i,
   output logic             run_o,
   output logic             acc_o,
   output logic             fatal_o
);
   localparam logic [COL_W-1:0] FATAL_C = {{(COL_W-1){1'b1}}, 1'b0};

   logic run_q;
   logic fatal_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q   <= 1'b0;
         fatal_q <= 1'b0;
      end else if (clr_i) begin
         run_q   <= 1'b1;
         fatal_q <= 1'b0;
      end else begin
         if (done_i)    run_q   <= 1'b0;
         if (fat_evt_i) fatal_q <= 1'b1;
      end
   end

   assign acc_o   = run_q && vld_i && !clr_i && (col_i < FATAL_C);
   assign run_o   = run_q;
   assign fatal_o = fatal_q;
endmodule

// File: rtl/bist_col_fail_rec.sv
module bist_col_fail_rec #(
   parameter int NUM_QUADS = 4,
   parameter int BANK_W    = 3,
   parameter int COL_W     = 7,
   parameter int QSEL_W    = (NUM_QUADS > 1) ? $clog2(NUM_QUADS) : 1,
   parameter int REC_W     = 2 * COL_W + BANK_W,
   parameter int STAT_W    = 2 * REC_W
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              clr,
   input  logic                              done,
   input  logic                              fail_vld,
   input  logic [QSEL_W-1:0]                 fail_quad,
   input  logic [BANK_W-1:0]                 fail_bank,
   input  logic [COL_W-1:0]                  fail_col,
   input  logic                              fail_hi,
   output logic [NUM_QUADS-1:0][STAT_W-1:0]  q_stat,
   output logic                              fatal
);
   if (COL_W < 2) begin : g_bad_col
      $error("COL_W must leave room for the two sentinel codes");
   end
   if (BANK_W < 1) begin : g_bad_bank
      $error("BANK_W must be at least 1");
   end
   if (NUM_QUADS < 1) begin : g_bad_quads
      $error("NUM_QUADS must be at least 1");
   end

   logic                 run_w;
   logic                 acc_w;
   logic [NUM_QUADS-1:0] fat_evt;

   bist_rec_seq #(.COL_W(COL_W)) seq_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr_i     (clr),
      .done_i    (done),
      .vld_i     (fail_vld),
      .col_i     (fail_col),
      .fat_evt_i (|fat_evt),
      .run_o     (run_w),
      .acc_o     (acc_w),
      .fatal_o   (fatal)
   );

   for (genvar q = 0; q < NUM_QUADS; q++) begin : g_quad
      logic acc_q;
      assign acc_q = acc_w && (fail_quad == QSEL_W'(q));

      bist_quad_log #(
         .BANK_W (BANK_W),
         .COL_W  (COL_W),
         .REC_W  (REC_W),
         .STAT_W (STAT_W)
      ) log_i (
         .clk       (clk),
         .rst_n     (rst_n),
         .clr_i     (clr),
         .acc_i     (acc_q),
         .bank_i    (fail_bank),
         .col_i     (fail_col),
         .hi_i      (fail_hi),
         .stat_o    (q_stat[q]),
         .fat_evt_o (fat_evt[q])
      );
   end
endmodule

// File: rtl/bist_rec_chk.sv
module bist_rec_chk #(
   parameter int NUM_QUADS = 4,
   parameter int BANK_W    = 3,
   parameter int COL_W     = 7,
   parameter int REC_W     = 2 * COL_W + BANK_W,
   parameter int STAT_W    = 2 * REC_W
) (
   input logic                             clk,
   input logic                             rst_n,
   input logic                             clr,
   input logic                             fail_vld,
   input logic [COL_W-1:0]                 fail_col,
   input logic                             run,
   input logic [NUM_QUADS-1:0][STAT_W-1:0] q_stat,
   input logic                             fatal
);
   localparam logic [COL_W-1:0]  EMPTY_C = '1;
   localparam logic [COL_W-1:0]  FATAL_C = {{(COL_W-1){1'b1}}, 1'b0};
   localparam logic [BANK_W-1:0] NOBANK  = '1;

   logic any_fe;
   always_comb begin
      any_fe = 1'b0;
      for (int q = 0; q < NUM_QUADS; q++) begin
         for (int k = 0; k < 2; k++) begin
            for (int h = 0; h < 2; h++) begin
               if (q_stat[q][k*REC_W + h*COL_W +: COL_W] == FATAL_C) any_fe = 1'b1;
            end
         end
      end
   end

   AST_CLR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (q_stat == '1) && !fatal); // R2

   AST_FATAL_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      fatal == any_fe); // R8

   AST_FATAL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      !fail_vld |=> !$rose(fatal)); // R6

   AST_OFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !run) |=> ($stable(q_stat) && $stable(fatal))); // R9

   AST_RSVD_COL: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && fail_vld && (fail_col >= FATAL_C)) |=> $stable(q_stat)); // R10

   for (genvar q = 0; q < NUM_QUADS; q++) begin : g_q
      logic s1_empty, s2_empty;
      assign s1_empty = (q_stat[q][0 +: COL_W] == EMPTY_C) &&
                        (q_stat[q][COL_W +: COL_W] == EMPTY_C);
      assign s2_empty = (q_stat[q][REC_W +: COL_W] == EMPTY_C) &&
                        (q_stat[q][REC_W+COL_W +: COL_W] == EMPTY_C);

      AST_FILL_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
         !s2_empty |-> !s1_empty); // R3

      AST_EMPTY_BANK1: assert property (@(posedge clk) disable iff (!rst_n)
         s1_empty |-> (q_stat[q][2*COL_W +: BANK_W] == NOBANK)); // R1

      AST_EMPTY_BANK2: assert property (@(posedge clk) disable iff (!rst_n)
         s2_empty |-> (q_stat[q][REC_W+2*COL_W +: BANK_W] == NOBANK)); // R1
   end
endmodule

bind bist_col_fail_rec bist_rec_chk #(
   .NUM_QUADS (NUM_QUADS),
   .BANK_W    (BANK_W),
   .COL_W     (COL_W),
   .REC_W     (REC_W),
   .STAT_W    (STAT_W)
) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .clr      (clr),
   .fail_vld (fail_vld),
   .fail_col (fail_col),
   .run      (run_w),
   .q_stat   (q_stat),
   .fatal    (fatal)
);

// File: tb/bist_col_fail_rec_tb_top.sv
module bist_col_fail_rec_tb_top;
   localparam int CLK_P = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic clr = 1'b0, done = 1'b0, fail_vld = 1'b0, fail_hi = 1'b0;
   logic [1:0] fail_quad = '0;
   logic [2:0] fail_bank = '0;
   logic [6:0] fail_col = '0;
   logic [3:0][33:0] q_stat;
   logic fatal;

   int checks = 0;
   int fails = 0;

   always #(CLK_P/2) clk = ~clk;

   bist_col_fail_rec dut_i (
      .clk(clk), .rst_n(rst_n), .clr(clr), .done(done), .fail_vld(fail_vld),
      .fail_quad(fail_quad), .fail_bank(fail_bank), .fail_col(fail_col),
      .fail_hi(fail_hi), .q_stat(q_stat), .fatal(fatal)
   );

   // Reference model built from the requirements
   bit       m_used [4][2];
   bit [2:0] m_bank [4][2];
   bit [6:0] m_col  [4][2][2];   // [quad][slot][half: 0 low, 1 high]
   bit       m_fatal;
   bit       m_run;

   task automatic m_clear();
      for (int q = 0; q < 4; q++)
         for (int k = 0; k < 2; k++) begin
            m_used[q][k] = 0;
            m_bank[q][k] = 3'h7;
            m_col[q][k][0] = 7'h7F;
            m_col[q][k][1] = 7'h7F;
         end
      m_fatal = 0;
   endtask

   task automatic m_rep(int q, int b, int c, int h);
      int k;
      if (!m_run || c >= 'h7E) return;
      if (m_used[q][0] && m_bank[q][0] == 3'(b)) k = 0;
      else if (m_used[q][1] && m_bank[q][1] == 3'(b)) k = 1;
      else begin
         if (!m_used[q][0]) k = 0;
         else if (!m_used[q][1]) k = 1;
         else begin
            if (m_col[q][1][h] != 7'h7E) begin
               m_col[q][1][h] = 7'h7E;
               m_fatal = 1;
            end
            return;
         end
         m_used[q][k] = 1;
         m_bank[q][k] = 3'(b);
         m_col[q][k][h] = 7'(c);
         return;
      end
      if (m_col[q][k][h] == 7'h7F) m_col[q][k][h] = 7'(c);
      else if (m_col[q][k][h] != 7'(c) && m_col[q][k][h] != 7'h7E) begin
         m_col[q][k][h] = 7'h7E;
         m_fatal = 1;
      end
   endtask

   function automatic logic [135:0] m_stat();
      logic [135:0] r;
      for (int q = 0; q < 4; q++)
         for (int k = 0; k < 2; k++)
            r[q*34 + k*17 +: 17] = {m_bank[q][k], m_col[q][k][1], m_col[q][k][0]};
      return r;
   endfunction

   task automatic tick();
      @(posedge clk);
      #(CLK_P/4);
   endtask

   task automatic chk(string tag, logic [135:0] act, logic [135:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic chk_all(string tag);
      chk(tag, q_stat, m_stat());
      chk(tag, {135'd0, fatal}, {135'd0, m_fatal});
   endtask

   // One cycle of stimulus, model updated with the same rules
   task automatic apply(bit c_clr, bit c_done, bit vld, int q, int b, int c, int h);
      clr = c_clr; done = c_done; fail_vld = vld;
      fail_quad = 2'(q); fail_bank = 3'(b); fail_col = 7'(c); fail_hi = h[0];
      if (c_clr) begin
         m_clear();
         m_run = 1;
      end else begin
         if (vld) m_rep(q, b, c, h);
         if (c_done) m_run = 0;
      end
      tick();
      clr = 0; done = 0; fail_vld = 0;
   endtask

   task automatic rep(int q, int b, int c, int h);
      apply(0, 0, 1, q, b, c, h);
   endtask

   initial begin
      #(CLK_P * 150000);
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      void'($urandom(32'd4711));
      m_clear();
      m_run = 0;
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      // R1: reset state
      chk("R1 reset status", q_stat, {136{1'b1}});
      chk("R1 reset fatal", {135'd0, fatal}, 136'd0);
      // R9: report before first clear is ignored
      rep(0, 1, 4, 0);
      chk_all("R9 pre-session");

      apply(1, 0, 0, 0, 0, 0, 0);
      // R3, R1 layout: first failure into slot 1, low field
      rep(0, 2, 5, 0);
      chk("R1 R3 layout", {102'd0, q_stat[0]},
          {102'd0, 3'h7, 7'h7F, 7'h7F, 3'd2, 7'h7F, 7'h05});
      // R4: duplicate
      rep(0, 2, 5, 0);
      chk_all("R4 duplicate");
      // R5: other half of the same bank
      rep(0, 2, 9, 1);
      chk_all("R5 fill half");
      // R3: new bank into slot 2
      rep(0, 4, 3, 0);
      chk_all("R3 slot two");
      // R6: conflicting column in a filled field
      rep(0, 2, 6, 0);
      chk_all("R6 conflict");
      chk("R8 fatal set", {135'd0, fatal}, 136'd1);
      // R8: fatal sticky over further good reports
      rep(2, 1, 1, 1);
      chk_all("R8 sticky");
      // R2: clear
      apply(1, 0, 0, 0, 0, 0, 0);
      chk("R2 cleared", q_stat, {136{1'b1}});
      chk("R2 fatal cleared", {135'd0, fatal}, 136'd0);
      // R7: third distinct bank
      rep(1, 1, 1, 0);
      rep(1, 2, 2, 0);
      rep(1, 3, 3, 1);
      chk_all("R7 overflow");
      chk("R7 marker", {129'd0, q_stat[1][30:24]}, {129'd0, 7'h7E});
      // R11: clear with a report in the same cycle
      apply(1, 0, 1, 3, 5, 7, 0);
      chk("R11 clear wins", q_stat, {136{1'b1}});
      // R10: reserved column codes
      rep(3, 5, 'h7E, 0);
      rep(3, 5, 'h7F, 1);
      chk("R10 reserved cols", q_stat, {136{1'b1}});
      // R9: report with done is taken, later ones are not
      apply(0, 1, 1, 3, 6, 10, 1);
      chk_all("R9 report with done");
      rep(3, 6, 11, 1);
      rep(2, 0, 12, 0);
      chk_all("R9 frozen");

      // Seeded random stream mixed with clears and done strobes
      apply(1, 0, 0, 0, 0, 0, 0);
      for (int i = 0; i < 600; i++) begin
         int sel;
         int c;
         sel = $urandom % 40;
         c = (($urandom % 10) == 0) ? ('h7E + ($urandom % 2)) : ($urandom % 6);
         if (sel == 0)      apply(1, 0, ($urandom % 2) == 1, $urandom % 4, $urandom % 4, c, $urandom % 2);
         else if (sel == 1) apply(0, 1, 0, 0, 0, 0, 0);
         else if (sel == 2 && !m_run) apply(1, 0, 0, 0, 0, 0, 0);
         else rep($urandom % 4, $urandom % 4, c, $urandom % 2);
         if (!m_run && ($urandom % 4) == 0) apply(1, 0, 0, 0, 0, 0, 0);
         chk_all("R3 R4 R5 R6 R7 R8 random");
      end

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule